// File: doc/BRIEF.md
# Buffer-to-DRAM Physical Address Calculator

This block converts a logical buffer choice into a physical DRAM start address. It serves two requesters, a host port and a DMA port. Each requester has its own encoded buffer size and its own buffer pointer. The start address is the pointer multiplied by the decoded buffer size. When the selected requester's data path is wider than the DRAM data path, that product is also multiplied by the ratio of the two widths. The host path is always one byte wide. The DMA path is one or two bytes wide, as chosen by a flag.

A one-cycle `start` strobe latches the result. The address appears on the next clock together with a single-cycle valid pulse. After that, each cycle with `incr` high advances the running address by one requester word, scaled into DRAM units. Every size code decodes to a power of two, so all multiplies and divides reduce to shifts. All arithmetic wraps at the DRAM address width.

Top module: `bufaddr_calc`

## Requirements
- R1: After reset, `addr_o` is 0, `addr_vld` is 0 and `cfg_err` is 0.
- R2: A size code n decodes to 2^(n+8) bytes. When the requester width is no wider than the DRAM width, a start loads `addr_o` with pointer × 2^(n+8).
- R3: `dram_wcode` maps 0/1/2/3 to a DRAM width of 1/4/8/16 bits. The host width is 8 bits. The DMA width is 16 bits when `dma_wide`=1 and 8 bits otherwise. When the requester width exceeds the DRAM width, the R2 product is multiplied by requester width / DRAM width.
- R4: `req_sel`=0 uses only the host size and pointer. `req_sel`=1 uses only the DMA size, pointer and width flag. The fields of the unselected requester have no effect.
- R5: The address is presented on the clock after a valid start, and `addr_vld` is high for exactly that one cycle. `addr_vld` is never high unless the previous cycle had a valid start.
- R6: With a 4-bit DRAM, a 16-bit DMA, size code 4 (4096 bytes) and pointer 2, the address is 0x8000.
- R7: A size code above `SIZE_MAX` (default 11) is invalid. A start with an invalid code leaves `addr_o` unchanged, gives no valid pulse and sets `cfg_err`. The next valid start clears `cfg_err`.
- R8: When `start` is low, each cycle with `incr` high adds a step to `addr_o` and gives no valid pulse. The step is (requester width / 8) × the R3 scale factor, fixed at the last valid start. With both `start` and `incr` low, `addr_o` holds.
- R9: All address results are reduced modulo 2^`ADDR_W` (default 24).
- R10: When `start` and `incr` are both high, the start takes priority and `addr_o` takes the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Compute and load a new start address |
| req_sel | input | 1 | 0 selects the host, 1 selects the DMA |
| host_size | input | SZC_W | Host encoded buffer size |
| host_ptr | input | PTR_W | Host buffer pointer |
| dma_size | input | SZC_W | DMA encoded buffer size |
| dma_ptr | input | PTR_W | DMA buffer pointer |
| dram_wcode | input | 2 | DRAM data width code |
| dma_wide | input | 1 | DMA path is 16 bits when high |
| incr | input | 1 | Advance the running address by one beat |
| addr_o | output | ADDR_W | Physical DRAM address |
| addr_vld | output | 1 | One-cycle pulse after a valid start |
| cfg_err | output | 1 | The last start had an invalid size code |

## Verification
The block has two pieces of internal state: the address register and the per-beat step latched at a start. A wrong shift amount or a wrong width decode shows on `addr_o` one clock after the offending start, as a value off by a power of two. A wrong latched step shows only through `incr`, so the bench checks every beat after a start. An error or valid flag that fails to update shows on the same clock edge as the address, which is why every start is checked for its pulse and for the cycle that follows it.

// File: rtl/bufaddr_calc.sv
module bufaddr_calc #(
  parameter int ADDR_W    = 24,
  parameter int PTR_W     = 8,
  parameter int SZC_W     = 4,
  parameter int SIZE_BASE = 8,
  parameter int SIZE_MAX  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_sel,
  input  logic [SZC_W-1:0]  host_size,
  input  logic [PTR_W-1:0]  host_ptr,
  input  logic [SZC_W-1:0]  dma_size,
  input  logic [PTR_W-1:0]  dma_ptr,
  input  logic [1:0]        dram_wcode,
  input  logic              dma_wide,
  input  logic              incr,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld,
  output logic              cfg_err
);
  localparam int SH_W = 7;

  logic [SZC_W-1:0]  sz_code;
  logic [PTR_W-1:0]  ptr;
  logic [2:0]        dram_lg, req_lg, scale;
  logic [SH_W-1:0]   tot_sh, step_sh;
  logic              sz_ok;
  logic [ADDR_W-1:0] start_addr, step_n, step_q;

  assign sz_code = req_sel ? dma_size : host_size;
  assign ptr     = req_sel ? dma_ptr  : host_ptr;
  assign sz_ok   = int'(sz_code) <= SIZE_MAX;

  assign dram_lg = (dram_wcode == 2'd0) ? 3'd0 :
                   (dram_wcode == 2'd1) ? 3'd2 :
                   (dram_wcode == 2'd2) ? 3'd3 : 3'd4;
  assign req_lg  = (req_sel && dma_wide) ? 3'd4 : 3'd3;
  assign scale   = (req_lg > dram_lg) ? req_lg - dram_lg : 3'd0;

  assign tot_sh     = SH_W'(sz_code) + SH_W'(SIZE_BASE) + SH_W'(scale);
  assign step_sh    = SH_W'(req_lg) - SH_W'(3) + SH_W'(scale);
  assign start_addr = ADDR_W'(ptr) << tot_sh;
  assign step_n     = ADDR_W'(1) << step_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o   <= '0;
      step_q   <= '0;
      addr_vld <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      addr_vld <= 1'b0;
      if (start) begin
        if (sz_ok) begin
          addr_o   <= start_addr;
          step_q   <= step_n;
          addr_vld <= 1'b1;
          cfg_err  <= 1'b0;
        end else begin
          cfg_err  <= 1'b1;
        end
      end else if (incr) begin
        addr_o <= addr_o + step_q;
      end
    end
  end
endmodule

// File: rtl/bufaddr_calc_chk.sv
module bufaddr_calc_chk #(
  parameter int ADDR_W   = 24,
  parameter int PTR_W    = 8,
  parameter int SZC_W    = 4,
  parameter int SIZE_MAX = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              req_sel,
  input logic [SZC_W-1:0]  host_size,
  input logic [SZC_W-1:0]  dma_size,
  input logic              incr,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_vld,
  input logic              cfg_err
);
  logic [SZC_W-1:0] sel_sz;
  logic             good;
  assign sel_sz = req_sel ? dma_size : host_size;
  assign good   = int'(sel_sz) <= SIZE_MAX;

  a_r5_vld_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && good) |=> addr_vld);
  a_r5_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && good) |=> !addr_vld);
  a_r7_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !good) |=> (cfg_err && $stable(addr_o)));
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && good) |=> !cfg_err);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !incr) |=> ($stable(addr_o) && $stable(cfg_err)));
endmodule

bind bufaddr_calc bufaddr_calc_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .SZC_W(SZC_W), .SIZE_MAX(SIZE_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_sel(req_sel),
  .host_size(host_size), .dma_size(dma_size), .incr(incr),
  .addr_o(addr_o), .addr_vld(addr_vld), .cfg_err(cfg_err)
);

// File: tb/bufaddr_calc_bench.sv
module bufaddr_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, req_sel = 1'b0, dma_wide = 1'b0, incr = 1'b0;
  logic [3:0]  host_size = '0, dma_size = '0;
  logic [7:0]  host_ptr = '0, dma_ptr = '0;
  logic [1:0]  dram_wcode = '0;
  logic [23:0] addr_o;
  logic        addr_vld, cfg_err;
  int          n_chk = 0, n_bad = 0;

  bufaddr_calc u_bufaddr_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .req_sel(req_sel),
    .host_size(host_size), .host_ptr(host_ptr), .dma_size(dma_size),
    .dma_ptr(dma_ptr), .dram_wcode(dram_wcode), .dma_wide(dma_wide),
    .incr(incr), .addr_o(addr_o), .addr_vld(addr_vld), .cfg_err(cfg_err)
  );

  always #2 clk = ~clk;

  function automatic int dwidth(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [23:0] model(input int p, input int code, input int rw, input int dw);
    longint v = longint'(p) * (longint'(256) << code);
    if (rw > dw) v = v * rw / dw;
    return v[23:0];
  endfunction

  function automatic logic [23:0] mstep(input int rw, input int dw);
    return 24'((rw / 8) * ((rw > dw) ? rw / dw : 1));
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(input logic sel, input logic [3:0] code, input logic [7:0] p,
                        input logic [1:0] dw, input logic wide, input logic with_incr);
    @(negedge clk);
    req_sel = sel; dram_wcode = dw; dma_wide = wide;
    if (sel) begin dma_size = code; dma_ptr = p; end
    else begin host_size = code; host_ptr = p; end
    start = 1'b1; incr = with_incr;
    @(negedge clk);
    start = 1'b0; incr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 addr", addr_o, 24'h0);
    chk("R1 vld", {23'b0, addr_vld}, 24'h0);
    chk("R1 err", {23'b0, cfg_err}, 24'h0);
  endtask

  task automatic t_direct;
    launch(1'b0, 4'd0, 8'h05, 2'd3, 1'b0, 1'b0);
    chk("R2 host", addr_o, 24'h000500);
    chk("R5 vld high", {23'b0, addr_vld}, 24'h1);
    @(negedge clk);
    chk("R5 vld one cycle", {23'b0, addr_vld}, 24'h0);
    chk("R5 addr held", addr_o, 24'h000500);
    launch(1'b1, 4'd3, 8'h11, 2'd2, 1'b0, 1'b0);
    chk("R2 dma narrow", addr_o, model(8'h11, 3, 8, 8));
  endtask

  task automatic t_scale;
    for (int dw = 0; dw < 4; dw++) begin
      for (int m = 0; m < 3; m++) begin
        logic sel  = (m != 0);
        logic wide = (m == 2);
        int   rw   = wide ? 16 : 8;
        launch(sel, 4'(dw + m), 8'(8'h13 + dw * 7 + m), 2'(dw), wide, 1'b0);
        chk("R3 scaled", addr_o, model(8'h13 + dw * 7 + m, dw + m, rw, dwidth(2'(dw))));
      end
    end
  endtask

  task automatic t_example;
    launch(1'b1, 4'd4, 8'd2, 2'd1, 1'b1, 1'b0);
    chk("R6 example", addr_o, 24'h008000);
  endtask

  task automatic t_select;
    @(negedge clk);
    dma_size = 4'd9; dma_ptr = 8'hAA; dma_wide = 1'b1;
    launch(1'b0, 4'd2, 8'h07, 2'd0, 1'b1, 1'b0);
    chk("R4 host only", addr_o, model(7, 2, 8, 1));
    @(negedge clk);
    host_size = 4'd10; host_ptr = 8'h55;
    launch(1'b1, 4'd1, 8'h03, 2'd2, 1'b1, 1'b0);
    chk("R4 dma only", addr_o, model(3, 1, 16, 8));
  endtask

  task automatic t_invalid;
    launch(1'b0, 4'd1, 8'h09, 2'd3, 1'b0, 1'b0);
    chk("R7 setup", addr_o, model(9, 1, 8, 16));
    launch(1'b0, 4'd12, 8'h21, 2'd3, 1'b0, 1'b0);
    chk("R7 addr held", addr_o, model(9, 1, 8, 16));
    chk("R7 no vld", {23'b0, addr_vld}, 24'h0);
    chk("R7 err set", {23'b0, cfg_err}, 24'h1);
    @(negedge clk);
    chk("R7 err sticky", {23'b0, cfg_err}, 24'h1);
    launch(1'b1, 4'd15, 8'h01, 2'd3, 1'b0, 1'b0);
    chk("R7 dma bad held", addr_o, model(9, 1, 8, 16));
    launch(1'b0, 4'd0, 8'h02, 2'd3, 1'b0, 1'b0);
    chk("R7 err clear", {23'b0, cfg_err}, 24'h0);
    chk("R7 recover", addr_o, 24'h000200);
  endtask

  task automatic t_incr;
    logic [23:0] e;
    launch(1'b1, 4'd4, 8'd2, 2'd1, 1'b1, 1'b0);
    e = 24'h008000;
    for (int i = 0; i < 3; i++) begin
      incr = 1'b1;
      @(negedge clk);
      e = e + mstep(16, 4);
      chk("R8 dma beat", addr_o, e);
      chk("R8 no vld", {23'b0, addr_vld}, 24'h0);
    end
    incr = 1'b0;
    @(negedge clk);
    chk("R8 hold", addr_o, e);
    launch(1'b0, 4'd0, 8'h01, 2'd2, 1'b0, 1'b0);
    incr = 1'b1;
    @(negedge clk);
    incr = 1'b0;
    chk("R8 host beat", addr_o, 24'h000100 + mstep(8, 8));
    launch(1'b0, 4'd0, 8'h01, 2'd0, 1'b0, 1'b0);
    incr = 1'b1;
    @(negedge clk);
    incr = 1'b0;
    chk("R8 host on 1-bit", addr_o, 24'h000800 + mstep(8, 1));
  endtask

  task automatic t_wrap;
    launch(1'b0, 4'd11, 8'hFF, 2'd3, 1'b0, 1'b0);
    chk("R9 wrap host", addr_o, model(255, 11, 8, 16));
    launch(1'b1, 4'd11, 8'hFF, 2'd0, 1'b1, 1'b0);
    chk("R9 wrap dma", addr_o, model(255, 11, 16, 1));
  endtask

  task automatic t_priority;
    launch(1'b0, 4'd0, 8'h30, 2'd3, 1'b0, 1'b0);
    launch(1'b0, 4'd0, 8'h40, 2'd3, 1'b0, 1'b1);
    chk("R10 start wins", addr_o, 24'h004000);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_scale();
    t_example();
    t_select();
    t_invalid();
    t_incr();
    t_wrap();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule